// File: doc/BRIEF.md
# Serial Register Access Slave

This block is the host-facing port of a 64-entry bank of 8-bit configuration registers. An external microcontroller acting as SPI master pulls the active-low select line, clocks in a command byte and then any number of data bytes, and releases select to end the burst. The command byte chooses between reading and writing, chooses whether the register address advances after each data byte or stays put, and gives the six-bit starting address.

The serial pins are brought into the core clock domain through a synchronizer, and SCK edges are detected from the synchronized level, so SCK must run well below the core clock. Two pin arrangements are supported: a four-wire arrangement with separate input and output data lines, and a three-wire arrangement in which one shared data line carries both directions. In that case the slave enables its driver only while it returns read data. Completed write bytes reach the register bank and also appear on a one-cycle write strobe at the ports.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, with select high, both output enables and the write strobe are low.
- R2: The first byte after select falls is a command: bit 7 = 1 selects a write and 0 selects a read, bit 6 = 1 enables auto-increment, and bits 5:0 are the start address. Bits are sent MSB first. Input is sampled on SCK rising edges and output changes on SCK falling edges (SPI mode 0).
- R3: In a write burst, each fully received data byte produces a one-cycle pulse of reg_we_o carrying the current address on reg_addr_o and the byte on reg_wdata_o, and that byte is stored in the register.
- R4: With auto-increment set, the address advances by one after every completed data byte and wraps from 0x3F to 0x00.
- R5: With auto-increment clear, every data byte of the burst uses the command's address.
- R6: In a read burst, sdo_o presents the addressed register MSB first, and the first bit is valid before the first SCK rising edge of each data byte.
- R7: A data byte cut short by select rising is discarded, and the next transaction again starts with a command byte.
- R8: In four-wire mode (three_wire_i = 0), miso_oe_o is high while select is low and low while select is high. sdio_oe_o stays low.
- R9: In three-wire mode (three_wire_i = 1), data is taken from sdio_i, miso_oe_o stays low, and sdio_oe_o is high only during the data bytes of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| three_wire_i | input | 1 | 1 selects the shared data line arrangement |
| cs_ni | input | 1 | Active-low slave select |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data in, four-wire mode |
| sdio_i | input | 1 | Shared data line input, three-wire mode |
| sdo_o | output | 1 | Serial data out, MSB first |
| miso_oe_o | output | 1 | Output enable for the four-wire output pin |
| sdio_oe_o | output | 1 | Output enable for the shared data pin |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 6 | Address of the register being written |
| reg_wdata_o | output | 8 | Data of the register being written |

## Verification
The assertions assume that three_wire_i is static during a transaction and that each SCK level lasts several core clocks, so that the synchronizer sees every edge. They also assume that SCK is low whenever select changes. The bench holds each SCK half period for six core clocks and sets select and the mode only while SCK is low. It changes data only in the low half of SCK and samples sdo_o just before each rising edge, as a mode-0 master would.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned WIDTH   = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= RST_VAL;
      else if (s == 0) pipe_q[s] <= async_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i)) mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_reg_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_act_i,
  input  logic          sck_i,
  input  logic          din_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          tx_bit_o,
  output phase_e        phase_o,
  output logic [$clog2(DW)-1:0] bit_cnt_o,
  output logic [AW-1:0] addr_o,
  output logic          wr_cmd_o,
  output logic          inc_o,
  output logic          byte_done_o
);
  localparam int unsigned CNT_W   = $clog2(DW);
  localparam int unsigned DIR_BIT = DW - 1;
  localparam int unsigned INC_BIT = DW - 2;

  logic              sck_q;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DW-1:0]     rx_q, rx_next, tx_q;
  logic [AW-1:0]     addr_q, next_addr;
  logic              wr_q, inc_q;
  phase_e            phase_q;
  logic              byte_done, cmd_done, data_done, rd_load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else sck_q <= sck_i;
  end

  assign sck_rise  = cs_act_i && sck_i && !sck_q;
  assign sck_fall  = cs_act_i && !sck_i && sck_q;
  assign rx_next   = {rx_q[DW-2:0], din_i};
  assign byte_done = sck_rise && (bit_cnt_q == CNT_W'(DW-1));
  assign cmd_done  = byte_done && (phase_q == PH_CMD);
  assign data_done = byte_done && (phase_q == PH_DATA);
  assign next_addr = inc_q ? addr_q + AW'(1) : addr_q;
  assign rd_addr_o = (phase_q == PH_CMD) ? rx_next[AW-1:0] : next_addr;
  // prefetch so the MSB is on the line before the first rise of the byte
  assign rd_load   = (cmd_done && !rx_next[DIR_BIT]) || (data_done && !wr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_q      <= '0;
      phase_q   <= PH_CMD;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      inc_q     <= 1'b0;
    end else if (!cs_act_i) begin
      bit_cnt_q <= '0;
      phase_q   <= PH_CMD;
    end else if (sck_rise) begin
      rx_q      <= rx_next;
      bit_cnt_q <= byte_done ? '0 : bit_cnt_q + CNT_W'(1);
      if (cmd_done) begin
        wr_q    <= rx_next[DIR_BIT];
        inc_q   <= rx_next[INC_BIT];
        addr_q  <= rx_next[AW-1:0];
        phase_q <= PH_DATA;
      end else if (data_done) begin
        addr_q  <= next_addr;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= '0;
    else if (rd_load) tx_q <= rd_data_i;
    else if (sck_fall && bit_cnt_q != '0) tx_q <= {tx_q[DW-2:0], 1'b0};
  end

  assign we_o        = data_done && wr_q;
  assign waddr_o     = addr_q;
  assign wdata_o     = rx_next;
  assign tx_bit_o    = tx_q[DW-1];
  assign phase_o     = phase_q;
  assign bit_cnt_o   = bit_cnt_q;
  assign addr_o      = addr_q;
  assign wr_cmd_o    = wr_q;
  assign inc_o       = inc_q;
  assign byte_done_o = byte_done;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int unsigned AW          = 6,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          three_wire_i,
  input  logic          cs_ni,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          sdio_i,
  output logic          sdo_o,
  output logic          miso_oe_o,
  output logic          sdio_oe_o,
  output logic          reg_we_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o
);
  localparam int unsigned CNT_W = $clog2(DW);

  logic [2:0]       pins_sync;
  logic             cs_act, sck_s, din_s;
  logic [AW-1:0]    rd_addr;
  logic [DW-1:0]    rd_data;
  logic             tx_bit;
  phase_e           phase;
  logic [CNT_W-1:0] bit_cnt;
  logic [AW-1:0]    addr;
  logic             wr_cmd, inc, byte_done;

  spi_pin_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({cs_ni, sck_i, three_wire_i ? sdio_i : mosi_i}),
    .sync_o (pins_sync)
  );

  assign cs_act = !pins_sync[2];
  assign sck_s  = pins_sync[1];
  assign din_s  = pins_sync[0];

  spi_frame_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sck_i      (sck_s),
    .din_i      (din_s),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .we_o       (reg_we_o),
    .waddr_o    (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .tx_bit_o   (tx_bit),
    .phase_o    (phase),
    .bit_cnt_o  (bit_cnt),
    .addr_o     (addr),
    .wr_cmd_o   (wr_cmd),
    .inc_o      (inc),
    .byte_done_o(byte_done)
  );

  spi_reg_bank #(.AW(AW), .DW(DW)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_o),
    .waddr_i(reg_addr_o),
    .wdata_i(reg_wdata_o),
    .raddr_i(rd_addr),
    .rdata_o(rd_data)
  );

  assign sdo_o     = tx_bit;
  assign miso_oe_o = cs_act && !three_wire_i;
  assign sdio_oe_o = cs_act && three_wire_i && (phase == PH_DATA) && !wr_cmd;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_pkg::*;
#(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  miso_oe_o,
  input logic                  sdio_oe_o,
  input logic                  reg_we_o,
  input logic                  cs_act,
  input logic                  byte_done,
  input phase_e                phase,
  input logic [$clog2(DW)-1:0] bit_cnt,
  input logic [AW-1:0]         addr,
  input logic                  inc
);
  localparam int unsigned CNT_W = $clog2(DW);

  assert_oe_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({miso_oe_o, sdio_oe_o}));

  assert_sdio_after_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdio_oe_o) |-> $past(byte_done));

  assert_oe_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |-> (!miso_oe_o && !sdio_oe_o));

  assert_idle_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> (bit_cnt == '0 && phase == PH_CMD));

  assert_we_full_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (bit_cnt == CNT_W'(DW-1) && phase == PH_DATA && cs_act));

  assert_addr_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && phase == PH_DATA && inc) |=> addr == AW'($past(addr) + 1'b1));

  assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && phase == PH_DATA && !inc) |=> $stable(addr));
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .miso_oe_o(miso_oe_o),
  .sdio_oe_o(sdio_oe_o),
  .reg_we_o (reg_we_o),
  .cs_act   (cs_act),
  .byte_done(byte_done),
  .phase    (phase),
  .bit_cnt  (bit_cnt),
  .addr     (addr),
  .inc      (inc)
);

// File: tb/spi_reg_slave_test.sv
module spi_reg_slave_test;
  localparam int HALF = 6;

  typedef struct packed {
    logic [5:0] addr;
    logic [7:0] data;
  } wr_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       three_wire = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic       sdio = 1'b0;
  logic       sdo, miso_oe, sdio_oe, reg_we;
  logic [5:0] reg_addr;
  logic [7:0] reg_wdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] model [64];
  wr_item_t   exp_q [$];

  always #4 clk = ~clk;

  spi_reg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .three_wire_i(three_wire), .cs_ni(cs_n),
    .sck_i(sck), .mosi_i(mosi), .sdio_i(sdio), .sdo_o(sdo),
    .miso_oe_o(miso_oe), .sdio_oe_o(sdio_oe), .reg_we_o(reg_we),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes (R3)
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        check("R3 unexpected write", {18'd0, reg_addr, reg_wdata}, 32'hFFFF_FFFF);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check("R3 write addr", 32'(reg_addr), 32'(it.addr));
        check("R3 write data", 32'(reg_wdata), 32'(it.data));
      end
    end
  end

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = tx[7-i];
      sdio = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx[7-i] = sdo;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sel_begin();
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    check("R8 miso_oe while selected", 32'(miso_oe), 32'(!three_wire));
  endtask

  task automatic sel_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    check("R8 miso_oe after deselect", 32'(miso_oe), 32'd0);
    check("R9 sdio_oe after deselect", 32'(sdio_oe), 32'd0);
  endtask

  task automatic wr_burst(input logic [5:0] a0, input bit inc, input int n, input logic [7:0] seed);
    logic [7:0] rx;
    logic [5:0] a;
    a = a0;
    sel_begin();
    xfer({1'b1, inc, a0}, 8, rx);
    check("R9 sdio_oe low in write", 32'(sdio_oe), 32'd0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = seed + 8'(k * 37);
      exp_q.push_back('{addr: a, data: d});
      model[a] = d;
      xfer(d, 8, rx);
      if (inc) a = a + 6'd1;
    end
    sel_end();
    check("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic rd_burst(input logic [5:0] a0, input bit inc, input int n, input string tag);
    logic [7:0] rx;
    logic [5:0] a;
    a = a0;
    sel_begin();
    xfer({1'b0, inc, a0}, 8, rx);
    for (int k = 0; k < n; k++) begin
      if (three_wire) check("R9 sdio_oe during read data", 32'(sdio_oe), 32'd1);
      xfer(8'h00, 8, rx);
      check(tag, 32'(rx), 32'(model[a]));
      if (inc) a = a + 6'd1;
    end
    sel_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 miso_oe in reset", 32'(miso_oe), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 miso_oe idle", 32'(miso_oe), 32'd0);
    check("R1 sdio_oe idle", 32'(sdio_oe), 32'd0);
    check("R1 write strobe idle", 32'(reg_we), 32'd0);

    // R2 R3 R4: incrementing write across the top address
    wr_burst(6'h3E, 1'b1, 3, 8'hA5);
    // R5: fixed-address write
    wr_burst(6'h10, 1'b0, 3, 8'h11);
    // R6 R4: incrementing read wraps back to 0
    rd_burst(6'h3E, 1'b1, 3, "R6 R4 read incrementing");
    rd_burst(6'h10, 1'b0, 2, "R5 R6 read fixed address");
    rd_burst(6'h01, 1'b1, 2, "R6 read untouched regs");

    // R7: partial byte is dropped
    sel_begin();
    xfer(8'hE0, 8, rx);
    exp_q.push_back('{addr: 6'h20, data: 8'h55});
    model[6'h20] = 8'h55;
    xfer(8'h55, 8, rx);
    xfer(8'hFF, 4, rx);
    sel_end();
    check("R7 no write from partial byte", 32'(exp_q.size()), 32'd0);
    rd_burst(6'h20, 1'b1, 2, "R7 read after partial");

    // R9: three-wire mode
    three_wire = 1'b1;
    mosi = 1'b0;
    wr_burst(6'h05, 1'b0, 1, 8'h9C);
    rd_burst(6'h05, 1'b0, 2, "R9 three-wire read");
    rd_burst(6'h3F, 1'b1, 2, "R9 R4 three-wire read wrap");
    three_wire = 1'b0;
    rd_burst(6'h05, 1'b0, 1, "R8 four-wire read back");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule